// File: doc/BRIEF.md
# Iterative SM3 Compression Round Engine

This block runs the 64-round SM3 compression on one 512-bit message block, one round per clock. A start pulse loads a 256-bit chaining value into eight working registers. After that the engine takes one pair of expanded message words per round from an upstream message-expansion unit, over a valid/ready stream. When the last round is done, the engine emits the new chaining value with a one-cycle done pulse. Each word of the new chaining value is the final working register XORed with the matching word of the input chaining value.

The word-pair stream follows these back-pressure rules. `w_ready` is high exactly while the engine is busy. A pair is accepted on every rising clock edge at which `w_valid` and `w_ready` are both high. While `w_valid` is low the engine stalls and holds all of its state. The producer must hold a pair until it is accepted. Padding, sequencing across several blocks and the choice of initial vector belong to the surrounding logic.

Top module: `sm3_compress_core`

## Requirements
- R1: After reset, `busy`, `w_ready` and `done` are low and `digest` is all zeros.
- R2: A `start` pulse while idle loads `cv_in` into the working registers. `busy` and `w_ready` are high from the next cycle. While idle, `w_ready` is low.
- R3: Exactly one round runs per accepted word pair. A cycle with `w_valid` low changes no state, so the result does not depend on gaps in the stream.
- R4: Rounds 0 to 15 use three-input parity for both boolean functions. Their constant is 0x79cc4519 rotated left by the round index (round 1 uses 0xf3988a32).
- R5: Rounds 16 to 63 use majority on (a,b,c) and choose on (e,f,g). Their constant is 0x7a879d8a rotated left by the round index mod 32.
- R6: Each round computes SS1, SS2, TT1 and TT2 modulo 2^32. It then moves the registers as follows: b and f shift into c and g with 9-bit and 19-bit left rotations; a and e shift into b and f; a takes TT1; e takes P0(TT2) = x^rotl(x,9)^rotl(x,17).
- R7: `digest` holds the input chaining value XOR the final registers. Word 0 (register a) sits in bits 255:224 and word 7 (h) in bits 31:0, the same layout as `cv_in`. The value holds until the next block completes.
- R8: `done` is high for exactly one cycle, in the cycle after the 64th pair is accepted. `busy` is low in that cycle.
- R9: A `start` pulse while busy is ignored and does not change the running block or its result.
- R10: With the standard initial vector and the padded block for "abc", the digest is 66c7f0f4 62eeedd9 d1f2d46b dc10e4e2 4167c487 5cf2f7a2 297da02b 8f4ba8e0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a block; used only while idle |
| cv_in | input | 256 | Input chaining value, word 0 in the top bits |
| w_valid | input | 1 | Word pair on `w_word`/`wx_word` is valid |
| w_ready | output | 1 | Engine accepts a pair this cycle |
| w_word | input | 32 | Expanded word Wt for the current round |
| wx_word | input | 32 | Mixed word W't = Wt xor Wt+4 for the current round |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-cycle pulse: `digest` is new |
| digest | output | 256 | New chaining value |

## Verification
An error in any single round, constant or rotation spreads through all eight registers within a few rounds. It therefore shows up as a wrong `digest` at the `done` pulse, 64 accepted pairs after `start`. A wrong round counter shows up as `done` arriving early or late compared with the count of accepted pairs. A stall that leaks state shows up only when the stream has gaps, so blocks are fed both back to back and with random idle cycles. A chaining value overwritten by a late `start` shows up as a wrong XOR in the final words.

// File: rtl/sm3_core_pkg.sv
package sm3_core_pkg;
  localparam int WORD_W = 32;
  localparam int NWORDS = 8;
  localparam logic [WORD_W-1:0] TBASE_EARLY = 32'h79cc4519;
  localparam logic [WORD_W-1:0] TBASE_LATE  = 32'h7a879d8a;

  // index 7 = register a (top word), index 0 = register h
  typedef logic [NWORDS-1:0][WORD_W-1:0] sm3_state_t;

  function automatic logic [WORD_W-1:0] rotl32(input logic [WORD_W-1:0] x,
                                               input logic [4:0] n);
    logic [2*WORD_W-1:0] tmp;
    tmp = {x, x} << n;
    return tmp[2*WORD_W-1:WORD_W];
  endfunction

  function automatic logic [WORD_W-1:0] perm0(input logic [WORD_W-1:0] x);
    return x ^ rotl32(x, 5'd9) ^ rotl32(x, 5'd17);
  endfunction
endpackage

// File: rtl/sm3_const_rot.sv
module sm3_const_rot
  import sm3_core_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int EARLY_ROUNDS = 16
) (
  input  logic [CNT_W-1:0]  rnd,
  output logic [WORD_W-1:0] tconst
);
  localparam int STAGES = 5;

  logic [WORD_W-1:0] stage [STAGES+1];

  assign stage[0] = (int'(rnd) < EARLY_ROUNDS) ? TBASE_EARLY : TBASE_LATE;

  for (genvar k = 0; k < STAGES; k++) begin : g_rot
    localparam int SH = 1 << k;
    assign stage[k+1] = rnd[k] ? {stage[k][WORD_W-1-SH:0], stage[k][WORD_W-1:WORD_W-SH]}
                               : stage[k];
  end

  assign tconst = stage[STAGES];
endmodule

// File: rtl/sm3_round_fn.sv
module sm3_round_fn
  import sm3_core_pkg::*;
(
  input  sm3_state_t        st,
  input  logic [WORD_W-1:0] w,
  input  logic [WORD_W-1:0] wx,
  input  logic [WORD_W-1:0] tconst,
  input  logic              late,
  output sm3_state_t        st_nxt
);
  logic [WORD_W-1:0] ra, rb, rc, rd, re, rf, rg, rh;
  logic [WORD_W-1:0] a_rot, ss1, ss2, ffv, ggv, tt1, tt2;

  always_comb begin
    ra = st[7]; rb = st[6]; rc = st[5]; rd = st[4];
    re = st[3]; rf = st[2]; rg = st[1]; rh = st[0];
    a_rot = rotl32(ra, 5'd12);
    ss1   = rotl32(a_rot + re + tconst, 5'd7);
    ss2   = ss1 ^ a_rot;
    if (late) begin
      ffv = ((ra | rc) & rb) | (ra & rc);
      ggv = ((rf ^ rg) & re) ^ rg;
    end else begin
      ffv = ra ^ rb ^ rc;
      ggv = re ^ rf ^ rg;
    end
    tt1 = ffv + rd + ss2 + wx;
    tt2 = ggv + rh + ss1 + w;
    st_nxt[7] = tt1;
    st_nxt[6] = ra;
    st_nxt[5] = rotl32(rb, 5'd9);
    st_nxt[4] = rc;
    st_nxt[3] = perm0(tt2);
    st_nxt[2] = re;
    st_nxt[1] = rotl32(rf, 5'd19);
    st_nxt[0] = rg;
  end
endmodule

// File: rtl/sm3_seq_ctrl.sv
module sm3_seq_ctrl #(
  parameter int NROUNDS = 64,
  parameter int CNT_W   = $clog2(NROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             w_valid,
  output logic             busy,
  output logic             load,
  output logic             fire,
  output logic             finish,
  output logic             done,
  output logic [CNT_W-1:0] rnd
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NROUNDS - 1);

  assign load   = start && !busy;
  assign fire   = busy && w_valid;
  assign finish = fire && (rnd == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rnd  <= '0;
      done <= 1'b0;
    end else begin
      done <= finish;
      if (load) begin
        busy <= 1'b1;
        rnd  <= '0;
      end else if (fire) begin
        rnd <= rnd + 1'b1;
        if (finish) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sm3_compress_core.sv
module sm3_compress_core
  import sm3_core_pkg::*;
#(
  parameter int NROUNDS      = 64,
  parameter int EARLY_ROUNDS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [255:0] cv_in,
  input  logic         w_valid,
  output logic         w_ready,
  input  logic [31:0]  w_word,
  input  logic [31:0]  wx_word,
  output logic         busy,
  output logic         done,
  output logic [255:0] digest
);
  localparam int CNT_W = $clog2(NROUNDS);

  logic             load, fire, finish;
  logic [CNT_W-1:0] rnd;
  logic [31:0]      tconst;
  sm3_state_t       st_q, st_nxt, cv_q;

  sm3_seq_ctrl #(.NROUNDS(NROUNDS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .w_valid(w_valid),
    .busy(busy), .load(load), .fire(fire), .finish(finish),
    .done(done), .rnd(rnd)
  );

  sm3_const_rot #(.CNT_W(CNT_W), .EARLY_ROUNDS(EARLY_ROUNDS)) u_const (
    .rnd(rnd), .tconst(tconst)
  );

  sm3_round_fn u_round (
    .st(st_q), .w(w_word), .wx(wx_word), .tconst(tconst),
    .late(int'(rnd) >= EARLY_ROUNDS), .st_nxt(st_nxt)
  );

  assign w_ready = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      cv_q   <= '0;
      digest <= '0;
    end else begin
      if (load) begin
        st_q <= sm3_state_t'(cv_in);
        cv_q <= sm3_state_t'(cv_in);
      end else if (fire) begin
        st_q <= st_nxt;
      end
      if (finish) digest <= 256'(cv_q) ^ 256'(st_nxt);
    end
  end
endmodule

// File: rtl/sm3_compress_chk.sv
module sm3_compress_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             w_valid,
  input logic             busy,
  input logic             done,
  input logic [255:0]     digest,
  input logic [CNT_W-1:0] rnd,
  input logic [255:0]     cv_hold
);
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_STALL_HOLDS_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !w_valid) |=> $stable(rnd)); // R3
  AST_DIGEST_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(digest)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_BUSY_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cv_hold)); // R9
endmodule

bind sm3_compress_core sm3_compress_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .w_valid(w_valid),
  .busy(busy), .done(done), .digest(digest), .rnd(rnd),
  .cv_hold(256'(cv_q))
);

// File: tb/sm3_compress_core_tb.sv
module sm3_compress_core_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [255:0] cv_in = '0;
  logic         w_valid = 1'b0;
  logic         w_ready;
  logic [31:0]  w_word = '0;
  logic [31:0]  wx_word = '0;
  logic         busy, done;
  logic [255:0] digest;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [255:0] exp_q[$];
  logic [31:0]  msg [16];
  logic [31:0]  wexp [68];

  always #(CLK_PERIOD/2) clk = ~clk;

  sm3_compress_core u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cv_in(cv_in),
    .w_valid(w_valid), .w_ready(w_ready), .w_word(w_word), .wx_word(wx_word),
    .busy(busy), .done(done), .digest(digest)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    int m;
    m = n % 32;
    if (m == 0) return x;
    return (x << m) | (x >> (32 - m));
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expand();
    for (int j = 0; j < 16; j++) wexp[j] = msg[j];
    for (int j = 16; j < 68; j++) begin
      logic [31:0] x;
      x = wexp[j-16] ^ wexp[j-9] ^ rl(wexp[j-3], 15);
      wexp[j] = (x ^ rl(x, 15) ^ rl(x, 23)) ^ rl(wexp[j-13], 7) ^ wexp[j-6];
    end
  endtask

  function automatic logic [255:0] model(input logic [255:0] cv);
    logic [31:0] v [8];
    logic [31:0] r [8];
    logic [255:0] res;
    for (int i = 0; i < 8; i++) begin
      v[i] = cv[255-32*i -: 32];
      r[i] = v[i];
    end
    for (int t = 0; t < 64; t++) begin
      logic [31:0] tj, a12, s1, s2, f1, g1, t1, t2;
      tj  = rl((t < 16) ? 32'h79cc4519 : 32'h7a879d8a, t);
      a12 = rl(r[0], 12);
      s1  = rl(a12 + r[4] + tj, 7);
      s2  = s1 ^ a12;
      f1  = (t < 16) ? (r[0] ^ r[1] ^ r[2]) : ((r[0] & r[1]) | (r[0] & r[2]) | (r[1] & r[2]));
      g1  = (t < 16) ? (r[4] ^ r[5] ^ r[6]) : ((r[4] & r[5]) | (~r[4] & r[6]));
      t1  = f1 + r[3] + s2 + (wexp[t] ^ wexp[t+4]);
      t2  = g1 + r[7] + s1 + wexp[t];
      r[3] = r[2]; r[2] = rl(r[1], 9); r[1] = r[0]; r[0] = t1;
      r[7] = r[6]; r[6] = rl(r[5], 19); r[5] = r[4];
      r[4] = t2 ^ rl(t2, 9) ^ rl(t2, 17);
    end
    for (int i = 0; i < 8; i++) res[255-32*i -: 32] = v[i] ^ r[i];
    return res;
  endfunction

  // driver: gaps=0 back to back, otherwise random idle cycles; intrude=1 pulses start mid block
  task automatic run_block(input logic [255:0] cv, input logic [255:0] expv,
                           input bit gaps, input bit intrude);
    expand();
    exp_q.push_back(expv);
    @(negedge clk);
    cv_in = cv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", {255'b0, busy}, 256'd1);
    check("R2 ready while busy", {255'b0, w_ready}, 256'd1);
    for (int t = 0; t < 64; t++) begin
      if (gaps) begin
        int idle;
        idle = int'($urandom_range(0, 2));
        for (int k = 0; k < idle; k++) begin
          w_valid = 1'b0;
          w_word  = $urandom;
          wx_word = $urandom;
          @(negedge clk);
        end
      end
      w_valid = 1'b1;
      w_word  = wexp[t];
      wx_word = wexp[t] ^ wexp[t+4];
      if (intrude && t == 20) begin
        start = 1'b1;
        cv_in = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      end
      @(negedge clk);
      start = 1'b0;
    end
    w_valid = 1'b0;
    check("R8 done after last pair", {255'b0, done}, 256'd1);
    @(negedge clk);
    check("R8 done one cycle", {255'b0, done}, 256'd0);
    check("R2 ready low when idle", {255'b0, w_ready}, 256'd0);
    check("R7 digest holds", digest, expv);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected done", 256'd1, 256'd0);
      end else begin
        logic [255:0] e;
        e = exp_q.pop_front();
        check("R3 R4 R5 R6 R7 digest", digest, e);
        check("R8 busy low at done", {255'b0, busy}, 256'd0);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  localparam logic [255:0] IV =
    256'h7380166f4914b2b9172442d7da8a0600a96f30bc163138aae38dee4db0fb0e4e;
  localparam logic [255:0] ABC_DIGEST =
    256'h66c7f0f462eeedd9d1f2d46bdc10e4e24167c4875cf2f7a2297da02b8f4ba8e0;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy at reset", {255'b0, busy}, 256'd0);
    check("R1 ready at reset", {255'b0, w_ready}, 256'd0);
    check("R1 done at reset", {255'b0, done}, 256'd0);
    check("R1 digest at reset", digest, 256'd0);
    rst_n = 1'b1;

    // R10: known vector, checked against the fixed value, not the model
    for (int j = 0; j < 16; j++) msg[j] = 32'h0;
    msg[0]  = 32'h61626380;
    msg[15] = 32'h00000018;
    run_block(IV, ABC_DIGEST, 1'b0, 1'b0);   // R10 back to back
    run_block(IV, ABC_DIGEST, 1'b1, 1'b0);   // R10 with stalls (R3)

    // random blocks, R4 R5 R6 against the bench model
    for (int b = 0; b < 6; b++) begin
      logic [255:0] cv;
      for (int j = 0; j < 16; j++) msg[j] = $urandom;
      cv = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      expand();
      run_block(cv, model(cv), b[0], b == 3);  // b==3: R9 start while busy
    end

    // all-ones block and chaining value: carries through every adder
    for (int j = 0; j < 16; j++) msg[j] = 32'hffffffff;
    expand();
    run_block({8{32'hffffffff}}, model({8{32'hffffffff}}), 1'b1, 1'b1);

    repeat (2) @(negedge clk);
    check("R8 scoreboard drained", 256'(exp_q.size()), 256'd0);
    finish_run();
  end
endmodule